// File: doc/BRIEF.md
# Synchronous Message Rendezvous Scheduler

This block schedules a fixed set of task contexts on one execution unit and carries messages between them by synchronous rendezvous. Each task owns one register-block slot and one message-buffer slot. A task switch only changes which register-block index the block presents to the execution unit. A message moves by exchanging buffer ownership between sender and receiver. No register or buffer contents are copied, and the storage arrays sit outside the block.

The running task issues send and receive requests on a valid/ready request stream. A request waits, with `req_valid` held and its fields stable, until `req_ready` is high at a rising edge. `req_ready` drops only in a cycle in which an interrupt message is being delivered. Each accepted request gets a one-cycle response pulse carrying a status code. Interrupt lines are turned into messages from a reserved pseudo-task and sent to fixed handler tasks. Task 0 is the idle task. It runs only when no other task is ready, and it never takes part in a rendezvous.

Top module: `sched_rendezvous`

## Requirements
- R1: While reset is held, the idle task 0 is active, task t owns buffer t, and `rsp_valid` is 0. On the first clock edge after reset, task 1 becomes active.
- R2: A request is accepted at a rising edge where `req_valid` and `req_ready` are both 1. One cycle later `rsp_valid` pulses with `rsp_status` set to OK=0, BLOCKED=1 or ERR=2. `req_op` is SEND=0 or RECV=1.
- R3: A SEND to task d completes with OK when d is blocked receiving from either this sender or the wildcard source (the all-ones peer code). The two tasks exchange buffers, d becomes ready, d's message source becomes the sender, and the sender stays active.
- R4: A SEND with no matching receiver returns BLOCKED, and the sender stops running.
- R5: A SEND to task 0, to an ID at or above NUM_TASKS, or to the sender itself returns ERR and changes nothing. A RECV naming task 0, itself or an out-of-range ID other than the wildcard or the interrupt pseudo-ID also returns ERR. Any request made while the idle task is active returns ERR.
- R6: A RECV that names a specific task completes only with a sender that is blocked toward it. Senders from other tasks stay blocked.
- R7: A wildcard RECV with several senders blocked toward the receiver takes the lowest task ID. Buffers are exchanged, and the receiver's message source becomes that ID.
- R8: After a blocking request, the next active task is the first ready task found by scanning upward from the blocked task with wrap-around and skipping task 0. If no task is ready, task 0 becomes active.
- R9: While task 0 is active, the first cycle that has a ready task switches to it by the same scan.
- R10: A pulse on interrupt line i is held pending until handler task i+1 is blocked receiving from the wildcard or from pseudo-ID NUM_TASKS. The handler then becomes ready with message source NUM_TASKS and its buffer unchanged. `req_ready` is 0 in the delivery cycle.
- R11: A RECV (wildcard or pseudo-ID) by a handler whose interrupt is already pending completes at once with OK and source NUM_TASKS, ahead of any blocked senders.
- R12: Every buffer slot is owned by exactly one task at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request from the active task is present |
| req_ready | output | 1 | Scheduler can take a request this cycle |
| req_op | input | 1 | 0 = SEND, 1 = RECV |
| req_peer | input | IDW | Destination (SEND) or source/wildcard/pseudo-ID (RECV) |
| irq_in | input | NUM_IRQ | Interrupt lines; line i is served by task i+1 |
| rsp_valid | output | 1 | Response pulse for the previous accepted request |
| rsp_status | output | 2 | OK=0, BLOCKED=1, ERR=2 |
| active_blk | output | TW | Register-block index connected to the execution unit |
| active_buf | output | TW | Buffer slot owned by the active task |
| active_msg_src | output | IDW | Source of the last message received by the active task |

## Verification
The bench builds the block with four tasks and three interrupt lines, so the peer code is 3 bits, the wildcard is 7 and the interrupt pseudo-ID is 4. With only three real tasks, every one of them can be blocked at the same time. This lets the bench reach the fall-back to the idle task, two senders queued on a single receiver, and a handler woken from idle by an interrupt. The third line gives task 3 a handler role, so the same receiver can block on interrupts and also pick among senders. Because the buffer swaps happen along a known path, the bench can track which task owns each buffer at every step.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic {OP_SEND = 1'b0, OP_RECV = 1'b1} op_e;
  typedef enum logic [1:0] {ST_OK = 2'd0, ST_BLOCKED = 2'd1, ST_ERR = 2'd2} status_e;
  typedef enum logic [1:0] {T_READY, T_RUNNING, T_SEND_BLK, T_RECV_BLK} tstate_e;
endpackage

// File: rtl/sched_low_pick.sv
module sched_low_pick #(
  parameter int N = 4,
  localparam int TW = $clog2(N)
) (
  input  logic [N-1:0]  mask,
  output logic          found,
  output logic [TW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int t = N - 1; t >= 0; t--) begin
      if (mask[t]) begin
        found = 1'b1;
        idx   = TW'(t);
      end
    end
  end

  // R7
  always_comb begin
    if (found) begin
      low_pick_lowest_chk: assert (mask[idx] && ((mask & ((N'(1) << idx) - N'(1))) == '0));
    end
  end
endmodule

// File: rtl/sched_rr_pick.sv
module sched_rr_pick #(
  parameter int N = 4,
  localparam int TW = $clog2(N)
) (
  input  logic [N-1:0]  mask,
  input  logic [TW-1:0] start,
  output logic          found,
  output logic [TW-1:0] grant
);
  always_comb begin
    found = 1'b0;
    grant = '0;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = int'(start) + k;
      if (c >= N) c = c - N;
      if (!found && mask[c]) begin
        found = 1'b1;
        grant = TW'(c);
      end
    end
  end

  // R8
  always_comb begin
    if (found) begin
      rr_grant_ready_chk: assert (mask[grant]);
    end
  end
endmodule

// File: rtl/sched_rendezvous.sv
module sched_rendezvous
  import sched_pkg::*;
#(
  parameter int NUM_TASKS = 4,
  parameter int NUM_IRQ   = 3,   // must not exceed NUM_TASKS-1
  localparam int TW  = $clog2(NUM_TASKS),
  localparam int IDW = $clog2(NUM_TASKS + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_op,
  input  logic [IDW-1:0]     req_peer,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic               rsp_valid,
  output logic [1:0]         rsp_status,
  output logic [TW-1:0]      active_blk,
  output logic [TW-1:0]      active_buf,
  output logic [IDW-1:0]     active_msg_src
);
  localparam logic [IDW-1:0] ANY_ID = {IDW{1'b1}};
  localparam logic [IDW-1:0] IRQ_ID = IDW'(NUM_TASKS);

  logic [TW-1:0]      cur;
  tstate_e            tstate [NUM_TASKS];
  logic [IDW-1:0]     peer_q [NUM_TASKS];
  logic [TW-1:0]      buf_q  [NUM_TASKS];
  logic [IDW-1:0]     src_q  [NUM_TASKS];
  logic [NUM_IRQ-1:0] pend_q;

  logic [NUM_IRQ-1:0]   deliver, take;
  logic [NUM_TASKS-1:0] ready_mask, snd_mask;
  logic                 req_fire, peer_real, send_ok, recv_ok, rx_match, irq_hit;
  logic                 snd_found, rr_found;
  logic [TW-1:0]        snd_idx, rr_idx, peer_tw;
  logic [IDW-1:0]       cur_id;

  assign cur_id    = IDW'(cur);
  assign peer_tw   = req_peer[TW-1:0];
  assign req_fire  = req_valid && req_ready;
  assign peer_real = (req_peer != '0) && (int'(req_peer) < NUM_TASKS) && (req_peer != cur_id);
  assign send_ok   = peer_real;
  assign recv_ok   = peer_real || (req_peer == IRQ_ID) || (req_peer == ANY_ID);
  assign rx_match  = send_ok && (tstate[peer_tw] == T_RECV_BLK) &&
                     ((peer_q[peer_tw] == cur_id) || (peer_q[peer_tw] == ANY_ID));

  always_comb begin
    irq_hit = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      deliver[i] = pend_q[i] && (tstate[i+1] == T_RECV_BLK) &&
                   ((peer_q[i+1] == ANY_ID) || (peer_q[i+1] == IRQ_ID));
      if (int'(cur) == i + 1 && pend_q[i] && (req_peer == ANY_ID || req_peer == IRQ_ID))
        irq_hit = 1'b1;
      take[i] = req_fire && (req_op == OP_RECV) && int'(cur) == i + 1 && irq_hit;
    end
    for (int t = 0; t < NUM_TASKS; t++) begin
      ready_mask[t] = (t != 0) && (tstate[t] == T_READY);
      snd_mask[t]   = (tstate[t] == T_SEND_BLK) && (peer_q[t] == cur_id) &&
                      ((req_peer == ANY_ID) || (req_peer == IDW'(t)));
    end
  end

  assign req_ready = ~|deliver;

  sched_low_pick #(.N(NUM_TASKS)) u_low (.mask(snd_mask), .found(snd_found), .idx(snd_idx));
  sched_rr_pick  #(.N(NUM_TASKS)) u_rr  (.mask(ready_mask), .start(cur), .found(rr_found), .grant(rr_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur        <= '0;
      pend_q     <= '0;
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      for (int t = 0; t < NUM_TASKS; t++) begin
        tstate[t] <= (t == 0) ? T_RUNNING : T_READY;
        peer_q[t] <= '0;
        buf_q[t]  <= TW'(t);
        src_q[t]  <= '0;
      end
    end else begin
      rsp_valid <= req_fire;
      pend_q    <= (pend_q & ~deliver & ~take) | irq_in;
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (deliver[i]) begin
          tstate[i+1] <= T_READY;
          src_q[i+1]  <= IRQ_ID;
        end
      end
      if (cur == '0 && rr_found) begin
        cur            <= rr_idx;
        tstate[rr_idx] <= T_RUNNING;
      end
      if (req_fire) begin
        if (cur == '0 || !(req_op == OP_SEND ? send_ok : recv_ok)) begin
          rsp_status <= ST_ERR;
        end else if (req_op == OP_SEND && rx_match) begin
          rsp_status      <= ST_OK;
          buf_q[cur]      <= buf_q[peer_tw];
          buf_q[peer_tw]  <= buf_q[cur];
          tstate[peer_tw] <= T_READY;
          src_q[peer_tw]  <= cur_id;
        end else if (req_op == OP_RECV && irq_hit) begin
          rsp_status <= ST_OK;
          src_q[cur] <= IRQ_ID;
        end else if (req_op == OP_RECV && snd_found) begin
          rsp_status      <= ST_OK;
          buf_q[cur]      <= buf_q[snd_idx];
          buf_q[snd_idx]  <= buf_q[cur];
          tstate[snd_idx] <= T_READY;
          src_q[cur]      <= IDW'(snd_idx);
        end else begin
          rsp_status  <= ST_BLOCKED;
          tstate[cur] <= (req_op == OP_SEND) ? T_SEND_BLK : T_RECV_BLK;
          peer_q[cur] <= req_peer;
          cur         <= rr_found ? rr_idx : '0;
          if (rr_found) tstate[rr_idx] <= T_RUNNING;
        end
      end
    end
  end

  assign active_blk     = cur;
  assign active_buf     = buf_q[cur];
  assign active_msg_src = src_q[cur];

  // R12
  generate
    for (genvar b = 0; b < NUM_TASKS; b++) begin : g_own
      logic [NUM_TASKS-1:0] owners;
      always_comb
        for (int t = 0; t < NUM_TASKS; t++) owners[t] = (buf_q[t] == TW'(b));
      buf_single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(owners) == 1);
    end
  endgenerate

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> rsp_valid);

  // R5
  self_send_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && req_op == OP_SEND && req_peer == cur_id) |=> rsp_status == ST_ERR);

  // R9
  idle_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == '0 && |ready_mask && !req_fire) |=> cur != '0);

  // R8
  active_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur != '0 |-> tstate[cur] == T_RUNNING);
endmodule

// File: tb/sched_rendezvous_bench.sv
module sched_rendezvous_bench;
  localparam int NT = 4, NI = 3, TW = 2, IDW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_op = 1'b0;
  logic [IDW-1:0] req_peer = '0;
  logic [NI-1:0] irq_in = '0;
  logic req_ready, rsp_valid;
  logic [1:0] rsp_status;
  logic [TW-1:0] active_blk, active_buf;
  logic [IDW-1:0] active_msg_src;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sched_rendezvous #(.NUM_TASKS(NT), .NUM_IRQ(NI)) u_sched_rendezvous (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_peer(req_peer), .irq_in(irq_in), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .active_blk(active_blk), .active_buf(active_buf),
    .active_msg_src(active_msg_src));

  // op, peer, status, blk, buf, src
  localparam logic [12:0] VECS [15] = '{
    {1'b1, 3'd7, 2'd1, 2'd2, 2'd2, 3'd0},  // R4 R8 recv any, nobody
    {1'b0, 3'd1, 2'd0, 2'd2, 2'd1, 3'd0},  // R3 send to waiting receiver
    {1'b0, 3'd3, 2'd1, 2'd3, 2'd3, 3'd0},  // R4 send to ready task
    {1'b0, 3'd3, 2'd2, 2'd3, 2'd3, 3'd0},  // R5 self send
    {1'b0, 3'd5, 2'd2, 2'd3, 2'd3, 3'd0},  // R5 nonexistent
    {1'b1, 3'd1, 2'd1, 2'd1, 2'd2, 3'd2},  // R6 specific source ignores task 2
    {1'b0, 3'd3, 2'd0, 2'd1, 2'd3, 3'd2},  // R3 R6 send to specific receiver
    {1'b1, 3'd7, 2'd1, 2'd3, 2'd2, 3'd1},  // R8 scan skips blocked task 2
    {1'b1, 3'd7, 2'd0, 2'd3, 2'd1, 3'd2},  // R7 single pending sender
    {1'b0, 3'd2, 2'd1, 2'd2, 2'd2, 3'd0},  // R8 wrap past idle and blocked
    {1'b0, 3'd1, 2'd0, 2'd2, 2'd3, 3'd0},  // R3 wildcard receiver
    {1'b1, 3'd7, 2'd0, 2'd2, 2'd1, 3'd3},  // R7 wildcard recv
    {1'b0, 3'd3, 2'd1, 2'd3, 2'd3, 3'd2},  // R4
    {1'b1, 3'd4, 2'd1, 2'd1, 2'd2, 3'd2},  // R10 wait for interrupt
    {1'b0, 3'd3, 2'd1, 2'd0, 2'd0, 3'd0}   // R8 none ready -> idle
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_req(input logic op, input logic [2:0] peer, input int st,
                        input int blk, input int bf, input int src, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_peer = peer;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, {req, " R2 rsp_valid"}, int'(rsp_valid), 1);
    chk(int'(rsp_status) == st, {req, " status"}, int'(rsp_status), st);
    chk(int'(active_blk) == blk, {req, " active_blk"}, int'(active_blk), blk);
    chk(int'(active_buf) == bf, {req, " R12 active_buf"}, int'(active_buf), bf);
    chk(int'(active_msg_src) == src, {req, " msg_src"}, int'(active_msg_src), src);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(active_blk == 0, "R1 reset blk", int'(active_blk), 0);
    chk(active_buf == 0, "R1 reset buf", int'(active_buf), 0);
    chk(rsp_valid == 0, "R1 reset rsp_valid", int'(rsp_valid), 0);
    chk(req_ready == 1, "R2 reset ready", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(active_blk == 1, "R1 first task", int'(active_blk), 1);
    chk(active_buf == 1, "R1 task1 owns buf1", int'(active_buf), 1);

    for (int v = 0; v < 15; v++) begin
      logic [12:0] e;
      e = VECS[v];
      do_req(e[12], e[11:9], int'(e[8:7]), int'(e[6:5]), int'(e[4:3]), int'(e[2:0]),
             $sformatf("vec%0d", v));
    end

    // R5 request from idle
    do_req(1'b0, 3'd1, 2, 0, 0, 0, "R5 idle request");

    // R10 interrupt to blocked handler task 3, R9 idle wakes
    @(negedge clk); irq_in = 3'b100;
    @(negedge clk); irq_in = '0;
    chk(req_ready == 0, "R10 ready low on delivery", int'(req_ready), 0);
    @(negedge clk);
    chk(active_blk == 0, "R9 still idle", int'(active_blk), 0);
    @(negedge clk);
    chk(active_blk == 3, "R9 idle switches", int'(active_blk), 3);
    chk(active_msg_src == 4, "R10 irq source", int'(active_msg_src), 4);
    chk(active_buf == 3, "R10 buffer kept", int'(active_buf), 3);

    do_req(1'b1, 3'd7, 0, 3, 2, 1, "R7 lowest sender first");
    do_req(1'b1, 3'd7, 0, 3, 1, 2, "R7 next sender");

    // R11 interrupt held for a running handler
    @(negedge clk); irq_in = 3'b001;
    @(negedge clk); irq_in = '0;
    chk(req_ready == 1, "R10 ready while pending", int'(req_ready), 1);
    do_req(1'b0, 3'd2, 1, 1, 3, 2, "R8 switch to handler");
    do_req(1'b1, 3'd7, 0, 1, 3, 4, "R11 pending irq taken");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule